// File: doc/BRIEF.md
# Peripheral Read/Write Strobe Sequencer

This block turns a single select request from the host side into one read or one write strobe toward a slow timer peripheral. The strobe has a fixed timing that is counted in cycles of the system clock. After the request, the block runs a counted wait. It then holds the strobe for a second counted period. Last comes a recovery gap of fixed length, and only after that gap does the block take another request. The direction of the access is latched at the moment the request is accepted. Only the matching strobe is raised.

A busy flag and the current state are brought out so the host side can observe the block. Select pulses that arrive while a sequence is running are dropped. An active-low reset returns the block to idle from any point in the sequence. The phase lengths are parameters: wait, strobe and recovery. The width of the shared phase counter follows from the longest of the three.

Top module: `strb_seq`

## Requirements
- R1: While rst_ni is low, state_o is 0 (idle), busy_o is 0 and rd_o and wr_o are both 0.
- R2: state_o encodes the states as idle=0, waiting=1, strobe=2, recovery=3. With sel_i low in idle, the block stays in idle.
- R3: If sel_i is high at a clock edge while the block is idle, state_o is 1 (waiting) after that edge.
- R4: The waiting state lasts exactly WAIT_CYCLES cycles (default 4). The block then moves to the strobe state.
- R5: The strobe state lasts exactly STROBE_CYCLES cycles (default 4). A strobe is high in every cycle of the strobe state and in no other state.
- R6: The recovery state lasts exactly RECOVER_CYCLES cycles (default 2). The block then returns to idle.
- R7: dir_i is captured at the edge where the block leaves idle. A captured 1 selects wr_o and a captured 0 selects rd_o. Later changes of dir_i during the sequence have no effect, and rd_o and wr_o are never high together.
- R8: A high sel_i while the block is not idle is ignored. It neither restarts nor extends the sequence.
- R9: busy_o is high in every state except idle.
- R10: If sel_i is held high, the block spends exactly one cycle in idle between two sequences.
- R11: Pulling rst_ni low during a sequence returns the block to idle at once and drops any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Timer-select request |
| dir_i | input | 1 | Access direction: 1 = write, 0 = read |
| rd_o | output | 1 | Read strobe toward the peripheral |
| wr_o | output | 1 | Write strobe toward the peripheral |
| busy_o | output | 1 | High while a sequence is running |
| state_o | output | 2 | Current sequencer state |

## Verification
The bench builds the block with its default lengths: four cycles of waiting, four of strobe and two of recovery. With these values the 2-bit phase counter reaches its top count of 3 in both counted phases. The recovery phase, by contrast, ends on a mid-range count, so both the full-count exit and an early exit are exercised. Every cycle of each sequence is compared against the expected state, strobe and busy values. This is done for both directions, for a direction flip in mid-sequence, for a select pulse during the strobe phase, for a select held high across back-to-back sequences, and for a reset that aborts a running sequence.

// File: rtl/strb_seq_pkg.sv
package strb_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_STRB  = 2'd2,
    ST_RECOV = 2'd3
  } seq_state_e;
endpackage

// File: rtl/strb_phase_cnt.sv
module strb_phase_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] term_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == term_i);
endmodule

// File: rtl/strb_fsm.sv
module strb_fsm
  import strb_seq_pkg::*;
#(
  parameter int WAIT_CYCLES    = 4,
  parameter int STROBE_CYCLES  = 4,
  parameter int RECOVER_CYCLES = 2,
  parameter int CNT_W          = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             last_i,
  output seq_state_e       state_o,
  output logic [CNT_W-1:0] term_o,
  output logic             clr_o,
  output logic             accept_o
);
  localparam logic [CNT_W-1:0] WAIT_TERM  = CNT_W'(WAIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] STRB_TERM  = CNT_W'(STROBE_CYCLES - 1);
  localparam logic [CNT_W-1:0] RECOV_TERM = CNT_W'(RECOVER_CYCLES - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    term_o  = '0;
    unique case (state_q)
      ST_IDLE:  if (sel_i) state_d = ST_WAIT;
      ST_WAIT:  begin term_o = WAIT_TERM;  if (last_i) state_d = ST_STRB;  end
      ST_STRB:  begin term_o = STRB_TERM;  if (last_i) state_d = ST_RECOV; end
      ST_RECOV: begin term_o = RECOV_TERM; if (last_i) state_d = ST_IDLE;  end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // counter restarts on each phase change and stays cleared in idle
  assign clr_o    = (state_d != state_q) || (state_q == ST_IDLE);
  assign accept_o = (state_q == ST_IDLE) && sel_i;
  assign state_o  = state_q;
endmodule

// File: rtl/strb_drive.sv
module strb_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic dir_i,
  input  logic active_i,
  output logic rd_o,
  output logic wr_o
);
  logic dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= 1'b0;
    else if (accept_i) dir_q <= dir_i;
  end

  assign wr_o = active_i &&  dir_q;
  assign rd_o = active_i && !dir_q;
endmodule

// File: rtl/strb_seq.sv
module strb_seq
  import strb_seq_pkg::*;
#(
  parameter int WAIT_CYCLES    = 4,
  parameter int STROBE_CYCLES  = 4,
  parameter int RECOVER_CYCLES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       dir_i,
  output logic       rd_o,
  output logic       wr_o,
  output logic       busy_o,
  output logic [1:0] state_o
);
  localparam int MAX_A  = (WAIT_CYCLES > STROBE_CYCLES) ? WAIT_CYCLES : STROBE_CYCLES;
  localparam int MAX_PH = (MAX_A > RECOVER_CYCLES) ? MAX_A : RECOVER_CYCLES;
  localparam int CNT_W  = (MAX_PH > 1) ? $clog2(MAX_PH) : 1;

  seq_state_e       state;
  logic [CNT_W-1:0] term, cnt;
  logic             clr, last, accept;

  strb_fsm #(
    .WAIT_CYCLES   (WAIT_CYCLES),
    .STROBE_CYCLES (STROBE_CYCLES),
    .RECOVER_CYCLES(RECOVER_CYCLES),
    .CNT_W         (CNT_W)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .last_i  (last),
    .state_o (state),
    .term_o  (term),
    .clr_o   (clr),
    .accept_o(accept)
  );

  strb_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .term_i(term),
    .cnt_o (cnt),
    .last_o(last)
  );

  strb_drive u_drive (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .dir_i   (dir_i),
    .active_i(state == ST_STRB),
    .rd_o    (rd_o),
    .wr_o    (wr_o)
  );

  assign busy_o  = (state != ST_IDLE);
  assign state_o = state;
endmodule

// File: rtl/strb_seq_chk.sv
module strb_seq_chk #(
  parameter int WAIT_CYCLES    = 4,
  parameter int STROBE_CYCLES  = 4,
  parameter int RECOVER_CYCLES = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       rd_o,
  input logic       wr_o,
  input logic       busy_o,
  input logic [1:0] state_o
);
  logic [15:0] run_q;
  logic [1:0]  prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      prev_q <= 2'd0;
    end else begin
      prev_q <= state_o;
      run_q  <= (state_o != prev_q) ? 16'd1 : run_q + 16'd1;
    end
  end

  AST_STROBE_IN_RW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> state_o == 2'd2);  // R5
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));  // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && !sel_i) |=> state_o == 2'd0);  // R2
  AST_IDLE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && sel_i) |=> state_o == 2'd1);  // R3
  AST_BUSY_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> state_o == 2'd1);  // R9
  AST_WAIT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && state_o == prev_q) |-> run_q < 16'(WAIT_CYCLES));  // R4
  AST_STRB_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && state_o == prev_q) |-> run_q < 16'(STROBE_CYCLES));  // R5
  AST_RECOV_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_q == 2'd3 && state_o == 2'd0) |-> run_q == 16'(RECOVER_CYCLES));  // R6
  AST_DIR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && prev_q == 2'd2) |-> (rd_o == $past(rd_o) && wr_o == $past(wr_o)));  // R7
endmodule

bind strb_seq strb_seq_chk #(
  .WAIT_CYCLES   (WAIT_CYCLES),
  .STROBE_CYCLES (STROBE_CYCLES),
  .RECOVER_CYCLES(RECOVER_CYCLES)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .rd_o   (rd_o),
  .wr_o   (wr_o),
  .busy_o (busy_o),
  .state_o(state_o)
);

// File: tb/strb_seq_tb.sv
module strb_seq_tb;
  localparam int WAIT_CYCLES    = 4;
  localparam int STROBE_CYCLES  = 4;
  localparam int RECOVER_CYCLES = 2;
  localparam int SEQ_LEN = WAIT_CYCLES + STROBE_CYCLES + RECOVER_CYCLES;

  logic clk_i = 1'b0, rst_ni = 1'b0, sel_i = 1'b0, dir_i = 1'b0;
  logic rd_o, wr_o, busy_o;
  logic [1:0] state_o;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  strb_seq #(
    .WAIT_CYCLES   (WAIT_CYCLES),
    .STROBE_CYCLES (STROBE_CYCLES),
    .RECOVER_CYCLES(RECOVER_CYCLES)
  ) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .dir_i  (dir_i),
    .rd_o   (rd_o),
    .wr_o   (wr_o),
    .busy_o (busy_o),
    .state_o(state_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected state j cycles after acceptance
  function automatic int exp_state(int j, bit hold);
    if (j < WAIT_CYCLES) return 1;
    if (j < WAIT_CYCLES + STROBE_CYCLES) return 2;
    if (j < SEQ_LEN) return 3;
    if (j == SEQ_LEN) return 0;
    return hold ? 1 : 0;
  endfunction

  function automatic string phase_req(int j, bit hold);
    if (j == 0) return "R3";
    if (j < WAIT_CYCLES) return "R4";
    if (j < WAIT_CYCLES + STROBE_CYCLES) return "R5";
    if (j < SEQ_LEN) return "R6";
    return hold ? "R10" : "R6";
  endfunction

  task automatic run_seq(bit d, bit hold, bit flip, bit poke);
    @(negedge clk_i);
    sel_i = 1'b1; dir_i = d;
    @(negedge clk_i);
    for (int j = 0; j <= SEQ_LEN + 1; j++) begin
      int es;
      es = exp_state(j, hold);
      chk(phase_req(j, hold), state_o, es);
      chk("R9 busy", busy_o, (es != 0) ? 1 : 0);
      if (j <= SEQ_LEN) begin
        chk(flip ? "R7 rd flip" : "R7 rd", rd_o, (es == 2 && !d) ? 1 : 0);
        chk(flip ? "R7 wr flip" : "R7 wr", wr_o, (es == 2 && d) ? 1 : 0);
      end
      sel_i = hold;
      if (flip) dir_i = ~d;
      if (poke && j == WAIT_CYCLES + 1) sel_i = 1'b1;
      if (poke && j == WAIT_CYCLES + 5) sel_i = 1'b1;
      @(negedge clk_i);
    end
    sel_i = 1'b0;
    repeat (SEQ_LEN + 2) @(negedge clk_i);
    chk(poke ? "R8 drained" : "R2 drained", state_o, 0);
  endtask

  task automatic t_reset_state();
    chk("R1 state", state_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 rd", rd_o, 0);
    chk("R1 wr", wr_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_idle_hold();
    sel_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk("R2 idle", state_o, 0);
    end
  endtask

  task automatic t_abort();
    @(negedge clk_i);
    sel_i = 1'b1; dir_i = 1'b1;
    @(negedge clk_i);
    sel_i = 1'b0;
    repeat (WAIT_CYCLES + 1) @(negedge clk_i);
    chk("R11 mid strobe", wr_o, 1);
    rst_ni = 1'b0;
    #1;
    chk("R11 state", state_o, 0);
    chk("R11 wr", wr_o, 0);
    chk("R11 busy", busy_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 stays idle", state_o, 0);
  endtask

  initial begin
    #3;
    t_reset_state();
    t_idle_hold();
    run_seq(1'b0, 1'b0, 1'b0, 1'b0);  // read
    run_seq(1'b1, 1'b0, 1'b0, 1'b0);  // write
    run_seq(1'b1, 1'b0, 1'b1, 1'b0);  // direction flip ignored
    run_seq(1'b0, 1'b0, 1'b0, 1'b1);  // select while busy ignored
    run_seq(1'b1, 1'b1, 1'b0, 1'b0);  // held select, back-to-back
    t_abort();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule